// File: doc/BRIEF.md
# Receive FIFO Burst Controller

This block sits between a receive MAC and a host DMA engine. It stores incoming frame bytes in a byte-wide FIFO. When enough data is readable it requests a DMA burst, and after the grant it delivers the burst one byte per clock. A frame's bytes become readable only once that frame has buffered its minimum release length (64 bytes by default) and the header-hold input is low. A frame that ends good becomes readable at its end, whatever its length. A frame that ends bad is discarded: the write pointer returns to the frame's first byte, so the next frame reuses that space. If the DMA side had already read into the discarded frame, the read pointer is moved back to the same place.

A separate priority output compares total FIFO occupancy, taken as the write pointer minus the read pointer, against a threshold. It tells a DMA arbiter shared with transmit to favour receive. A write that finds the FIFO full sets a sticky overflow flag and condemns the current frame.

The writer state machine has four states. W_IDLE is between frames. W_FILL means a frame is open but not yet readable. W_STREAM means the open frame is readable as it grows. W_DROP means the open frame is condemned and the block is waiting for its end. Writer transitions:
- W_IDLE to W_FILL on a start byte.
- W_FILL to W_STREAM on release.
- Any open state to W_IDLE on an end byte.
- W_FILL or W_STREAM, or W_IDLE on a start byte, to W_DROP on a write into a full FIFO.

The burst state machine has three states: B_IDLE, B_REQ (request raised, waiting for grant) and B_XFER (streaming). Burst transitions:
- B_IDLE to B_REQ when a request condition holds.
- B_REQ to B_XFER on grant.
- B_REQ to B_IDLE if the condition lapses or a frame is rejected.
- B_XFER to B_IDLE after the final byte, or at once on a rejection.

Top module: `rxf_dma_ctl`

## Requirements
- R1: After reset, dma_req, rd_valid, rd_last, rx_prio and overflow are all low.
- R2: Bytes of an open frame cannot be requested or read until the frame holds at least MIN_REL (64) bytes; a frame of 63 bytes with no end yet raises no request.
- R3: While hdr_hold is high, an open frame is not released even past MIN_REL bytes; within three cycles of hdr_hold falling a request is raised.
- R4: dma_req rises when readable bytes are at least the burst size; after dma_gnt is sampled high in a cycle with dma_req, rd_valid starts the next cycle and delivers min(burst size, readable) bytes, one per cycle, in write order, with rd_last high on the final byte. A burst_size of 0 means DEPTH.
- R5: After a frame ends good, its remaining bytes are requested and delivered even when fewer than the burst size remain; a frame whose length is not a multiple of the burst size ends with one short burst.
- R6: A frame whose end byte has in_good low delivers no bytes, and the next frame is delivered with its own data from the same space.
- R7: When a released frame whose first bytes were already read ends bad, the read side is moved back to that frame's start; occupancy returns to zero and the next frame is delivered intact.
- R8: rx_prio is high exactly when occupancy (bytes written and not read or discarded) is greater than prio_thresh.
- R9: A write while occupancy equals DEPTH drops the byte, sets overflow, which stays high until reset, and discards the whole frame even if its end byte has in_good high.
- R10: Bytes written outside a frame (no start byte seen in W_IDLE) are ignored and never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is presented this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_good | input | 1 | With in_eof: 1 accepts the frame, 0 rejects it |
| hdr_hold | input | 1 | Holds release of the open frame (header processing busy) |
| burst_size | input | PW | Bytes per DMA burst; 0 or above DEPTH means DEPTH |
| prio_thresh | input | PW | Occupancy threshold for rx_prio |
| dma_req | output | 1 | Burst request to the DMA engine |
| dma_gnt | input | 1 | Grant for the pending request |
| rd_valid | output | 1 | rd_data carries a burst byte |
| rd_data | output | 8 | Burst byte |
| rd_last | output | 1 | Final byte of the burst |
| rx_prio | output | 1 | Receive asks for priority over transmit |
| overflow | output | 1 | Sticky: a write met a full FIFO |

## Verification
The hardest situation to reach is a rejected frame whose first bytes the DMA side has already read. The read pointer must then move back as well as the write pointer, or the next frame is corrupted. The bench gets there by writing 70 bytes of an open frame so that it is released, and granting exactly one 16-byte burst. It then finishes the frame with a bad end byte and checks that occupancy falls to zero and that a following frame comes out byte for byte. Overflow is reached by filling all 128 entries of a frame with no end byte and then writing one more byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        W_IDLE,
        W_FILL,
        W_STREAM,
        W_DROP
    } wr_state_e;

    typedef enum logic [1:0] {
        B_IDLE,
        B_REQ,
        B_XFER
    } burst_state_e;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rxf_wr_ctl.sv
module rxf_wr_ctl
    import rxf_pkg::*;
#(
    parameter int DEPTH   = 128,
    parameter int MIN_REL = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_good,
    input  logic          hdr_hold,
    input  logic [PW-1:0] rd_ptr,
    output logic          mem_we,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] lim_ptr,
    output logic [PW-1:0] commit_ptr,
    output logic          rb_valid,
    output logic [PW-1:0] rb_ptr,
    output logic          overflow
);
    wr_state_e     state_q, state_n;
    logic [PW-1:0] sof_ptr;
    logic          rel_q;
    logic [PW-1:0] occ, fcnt, frame_start, wp_inc;
    logic          full, starting, take, accept, ovf_now;
    logic          eof_now, bad_end, good_end;

    always_comb begin
        occ         = wr_ptr - rd_ptr;
        full        = (occ == PW'(DEPTH));
        starting    = (state_q == W_IDLE) && in_valid && in_sof;
        take        = in_valid && (starting || state_q == W_FILL || state_q == W_STREAM);
        accept      = take && !full;
        ovf_now     = take && full;
        frame_start = starting ? wr_ptr : sof_ptr;
        fcnt        = wr_ptr - sof_ptr;
        eof_now     = in_valid && in_eof && (take || state_q == W_DROP);
        bad_end     = eof_now && (!in_good || ovf_now || state_q == W_DROP);
        good_end    = eof_now && !bad_end;
        wp_inc      = wr_ptr + PW'(accept);
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (starting) begin
                    if (eof_now)      state_n = W_IDLE;
                    else if (ovf_now) state_n = W_DROP;
                    else              state_n = W_FILL;
                end
            end
            W_FILL: begin
                if (eof_now)      state_n = W_IDLE;
                else if (ovf_now) state_n = W_DROP;
                else if (fcnt >= PW'(MIN_REL) && !hdr_hold) state_n = W_STREAM;
            end
            W_STREAM: begin
                if (eof_now)      state_n = W_IDLE;
                else if (ovf_now) state_n = W_DROP;
            end
            W_DROP: begin
                if (eof_now) state_n = W_IDLE;
            end
            default: state_n = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            sof_ptr    <= '0;
            commit_ptr <= '0;
            rel_q      <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            wr_ptr   <= bad_end ? frame_start : wp_inc;
            rel_q    <= (state_n == W_STREAM) || (rel_q && state_n == W_DROP);
            overflow <= overflow | ovf_now;
            if (starting) sof_ptr <= wr_ptr;
            if (good_end) commit_ptr <= wp_inc;
        end
    end

    always_comb begin
        mem_we   = accept;
        lim_ptr  = rel_q ? wr_ptr : commit_ptr;
        rb_valid = bad_end;
        rb_ptr   = frame_start;
    end
endmodule

// File: rtl/rxf_burst_ctl.sv
module rxf_burst_ctl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] burst_size,
    input  logic [PW-1:0] lim_ptr,
    input  logic [PW-1:0] commit_ptr,
    input  logic [PW-1:0] wr_ptr,
    input  logic          rb_valid,
    input  logic [PW-1:0] rb_ptr,
    input  logic          dma_gnt,
    output logic          dma_req,
    output logic          rd_valid,
    output logic          rd_last,
    output logic [PW-1:0] rd_ptr
);
    burst_state_e  state_q, state_n;
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] eff, avail, cav, blen;
    logic          flush, want, rb_hit;

    always_comb begin
        eff    = (burst_size == '0 || burst_size > PW'(DEPTH)) ? PW'(DEPTH) : burst_size;
        avail  = lim_ptr - rd_ptr;
        cav    = commit_ptr - rd_ptr;
        flush  = (cav != '0) && (cav <= avail);
        want   = (avail != '0) && ((avail >= eff) || flush);
        blen   = (avail < eff) ? avail : eff;
        rb_hit = rb_valid && ((rd_ptr - rb_ptr) <= (wr_ptr - rb_ptr));
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            B_IDLE: if (want && !rb_valid) state_n = B_REQ;
            B_REQ: begin
                if (rb_valid || !want) state_n = B_IDLE;
                else if (dma_gnt)      state_n = B_XFER;
            end
            B_XFER: begin
                if (rb_valid || cnt_q == PW'(1)) state_n = B_IDLE;
            end
            default: state_n = B_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= B_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (rb_hit)                   rd_ptr <= rb_ptr;
            else if (state_q == B_XFER)   rd_ptr <= rd_ptr + PW'(1);
            if (state_q == B_REQ && state_n == B_XFER) cnt_q <= blen;
            else if (state_q == B_XFER)                cnt_q <= cnt_q - PW'(1);
        end
    end

    always_comb begin
        dma_req  = (state_q == B_REQ);
        rd_valid = (state_q == B_XFER);
        rd_last  = (state_q == B_XFER) && (cnt_q == PW'(1));
    end
endmodule

// File: rtl/rxf_dma_ctl.sv
module rxf_dma_ctl #(
    parameter int DEPTH   = 128,
    parameter int MIN_REL = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_good,
    input  logic          hdr_hold,
    input  logic [PW-1:0] burst_size,
    input  logic [PW-1:0] prio_thresh,
    output logic          dma_req,
    input  logic          dma_gnt,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          rd_last,
    output logic          rx_prio,
    output logic          overflow
);
    logic          mem_we, rb_valid;
    logic [PW-1:0] wr_ptr, rd_ptr, lim_ptr, commit_ptr, rb_ptr;
    logic [PW-1:0] occ;

    rxf_wr_ctl #(.DEPTH(DEPTH), .MIN_REL(MIN_REL)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_good    (in_good),
        .hdr_hold   (hdr_hold),
        .rd_ptr     (rd_ptr),
        .mem_we     (mem_we),
        .wr_ptr     (wr_ptr),
        .lim_ptr    (lim_ptr),
        .commit_ptr (commit_ptr),
        .rb_valid   (rb_valid),
        .rb_ptr     (rb_ptr),
        .overflow   (overflow)
    );

    rxf_burst_ctl #(.DEPTH(DEPTH)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_size (burst_size),
        .lim_ptr    (lim_ptr),
        .commit_ptr (commit_ptr),
        .wr_ptr     (wr_ptr),
        .rb_valid   (rb_valid),
        .rb_ptr     (rb_ptr),
        .dma_gnt    (dma_gnt),
        .dma_req    (dma_req),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .rd_ptr     (rd_ptr)
    );

    rxf_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (in_data),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_data)
    );

    assign occ     = wr_ptr - rd_ptr;
    assign rx_prio = (occ > prio_thresh);
endmodule

// File: rtl/rxf_dma_ctl_chk.sv
module rxf_dma_ctl_chk #(
    parameter int DEPTH = 128,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_req,
    input logic          dma_gnt,
    input logic          rd_valid,
    input logic          rd_last,
    input logic          overflow,
    input logic [PW-1:0] occ
);
    assert_read_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (occ != '0));

    assert_burst_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(dma_req && dma_gnt));

    assert_last_ends_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> !rd_valid);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_occ_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));
endmodule

bind rxf_dma_ctl rxf_dma_ctl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_req  (dma_req),
    .dma_gnt  (dma_gnt),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .overflow (overflow),
    .occ      (occ)
);

// File: tb/rxf_dma_ctl_tb.sv
`timescale 1ns/100ps
module rxf_dma_ctl_tb;
    localparam int DEPTH = 128;
    localparam int PW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_good = 1'b0;
    logic [7:0]    in_data = '0;
    logic          hdr_hold = 1'b0;
    logic [PW-1:0] burst_size = 8'd8;
    logic [PW-1:0] prio_thresh = 8'd127;
    logic          dma_gnt = 1'b0;
    logic          dma_req, rd_valid, rd_last, rx_prio, overflow;
    logic [7:0]    rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rxf_dma_ctl #(.DEPTH(DEPTH), .MIN_REL(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_good(in_good), .hdr_hold(hdr_hold),
        .burst_size(burst_size), .prio_thresh(prio_thresh), .dma_req(dma_req),
        .dma_gnt(dma_gnt), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rx_prio(rx_prio), .overflow(overflow)
    );

    // {length, good, burst size, expected bytes, expected bursts}
    localparam logic [39:0] VEC [0:7] = '{
        {8'd10,  8'd1, 8'd4,   8'd10,  8'd3},
        {8'd64,  8'd1, 8'd16,  8'd64,  8'd4},
        {8'd100, 8'd1, 8'd32,  8'd100, 8'd4},
        {8'd50,  8'd0, 8'd8,   8'd0,   8'd0},
        {8'd128, 8'd1, 8'd128, 8'd128, 8'd1},
        {8'd1,   8'd1, 8'd8,   8'd1,   8'd1},
        {8'd90,  8'd0, 8'd16,  8'd0,   8'd0},
        {8'd33,  8'd1, 8'd10,  8'd33,  8'd4}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put_bytes(input int n, input int base, input bit sof, input bit eof,
                             input bit good, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 8'(base + i);
            in_sof   = sof && (i == 0);
            in_eof   = eof && (i == n - 1);
            in_good  = good;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req, input int exp_bytes, input int exp_bursts,
                         input logic [7:0] seed);
        int bytes = 0, bursts = 0, bad = 0, quiet = 0, guard = 0;
        dma_gnt = 1'b1;
        while (quiet < 6 && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (rd_valid) begin
                if (rd_data != seed + 8'(bytes)) bad++;
                bytes++;
                if (rd_last) bursts++;
            end
            quiet = (dma_req || rd_valid) ? 0 : quiet + 1;
        end
        dma_gnt = 1'b0;
        check(req, "bytes delivered", bytes, exp_bytes);
        check(req, "burst count", bursts, exp_bursts);
        check(req, "data mismatches", bad, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog (all R): actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle(2);
        // R1 reset state
        check("R1", "dma_req", int'(dma_req), 0);
        check("R1", "rd_valid", int'(rd_valid), 0);
        check("R1", "rd_last", int'(rd_last), 0);
        check("R1", "rx_prio", int'(rx_prio), 0);
        check("R1", "overflow", int'(overflow), 0);
        do_reset();

        // Table walk: R4 bursts, R5 short final burst, R6 rejected frames
        for (int v = 0; v < 8; v++) begin
            logic [7:0] seed;
            seed = 8'(v * 17 + 3);
            burst_size = VEC[v][23:16];
            put_bytes(int'(VEC[v][39:32]), 0, 1'b1, 1'b1, VEC[v][31:24] != 0, seed);
            drain((VEC[v][31:24] != 0) ? "R4/R5" : "R6", int'(VEC[v][15:8]),
                  int'(VEC[v][7:0]), seed);
            check("R6", "occupancy clear after vector", int'(rx_prio), 0);
        end

        // R6 space reuse after a reject
        put_bytes(20, 0, 1'b1, 1'b1, 1'b0, 8'h55);
        burst_size = 8'd8;
        put_bytes(12, 0, 1'b1, 1'b1, 1'b1, 8'hA0);
        drain("R6", 12, 2, 8'hA0);

        // R2 release gating at 64 bytes
        burst_size = 8'd8;
        put_bytes(63, 0, 1'b1, 1'b0, 1'b1, 8'h10);
        idle(4);
        check("R2", "no request at 63 bytes", int'(dma_req), 0);
        put_bytes(1, 63, 1'b0, 1'b0, 1'b1, 8'h10);
        idle(3);
        check("R2", "request after 64 bytes", int'(dma_req), 1);
        put_bytes(6, 64, 1'b0, 1'b1, 1'b1, 8'h10);
        drain("R2", 70, 9, 8'h10);

        // R3 header hold
        hdr_hold = 1'b1;
        put_bytes(80, 0, 1'b1, 1'b0, 1'b1, 8'h40);
        idle(4);
        check("R3", "held frame not requested", int'(dma_req), 0);
        hdr_hold = 1'b0;
        idle(3);
        check("R3", "request after hold drops", int'(dma_req), 1);
        put_bytes(1, 80, 1'b0, 1'b1, 1'b1, 8'h40);
        drain("R3", 81, 11, 8'h40);

        // R7 read-side rollback
        burst_size  = 8'd16;
        prio_thresh = 8'd0;
        put_bytes(70, 0, 1'b1, 1'b0, 1'b1, 8'h70);
        idle(3);
        begin
            int got = 0, bad = 0, guard = 0;
            bit fin = 1'b0;
            dma_gnt = 1'b1;
            while (!fin && guard < 100) begin
                @(negedge clk);
                guard++;
                if (rd_valid) begin
                    dma_gnt = 1'b0;
                    if (rd_data != 8'h70 + 8'(got)) bad++;
                    got++;
                    if (rd_last) fin = 1'b1;
                end
            end
            dma_gnt = 1'b0;
            check("R7", "partial burst bytes", got, 16);
            check("R7", "partial burst data", bad, 0);
        end
        put_bytes(30, 70, 1'b0, 1'b1, 1'b0, 8'h70);
        idle(2);
        check("R7", "occupancy zero after reject", int'(rx_prio), 0);
        check("R7", "no request after reject", int'(dma_req), 0);
        put_bytes(20, 0, 1'b1, 1'b1, 1'b1, 8'hC3);
        drain("R7", 20, 2, 8'hC3);

        // R8 priority threshold
        burst_size  = 8'd128;
        prio_thresh = 8'd40;
        put_bytes(40, 0, 1'b1, 1'b0, 1'b1, 8'h22);
        check("R8", "rx_prio at threshold", int'(rx_prio), 0);
        put_bytes(1, 40, 1'b0, 1'b0, 1'b1, 8'h22);
        check("R8", "rx_prio above threshold", int'(rx_prio), 1);
        put_bytes(1, 41, 1'b0, 1'b1, 1'b1, 8'h22);
        drain("R8", 42, 1, 8'h22);
        check("R8", "rx_prio after drain", int'(rx_prio), 0);

        // R10 bytes outside a frame
        burst_size = 8'd4;
        put_bytes(5, 0, 1'b0, 1'b1, 1'b1, 8'hEE);
        idle(3);
        check("R10", "no request for stray bytes", int'(dma_req), 0);
        put_bytes(3, 0, 1'b1, 1'b1, 1'b1, 8'h31);
        drain("R10", 3, 1, 8'h31);

        // R9 overflow
        prio_thresh = 8'd0;
        burst_size  = 8'd8;
        put_bytes(128, 0, 1'b1, 1'b0, 1'b1, 8'h90);
        check("R9", "no overflow when exactly full", int'(overflow), 0);
        put_bytes(1, 128, 1'b0, 1'b1, 1'b1, 8'h90);
        check("R9", "overflow set", int'(overflow), 1);
        drain("R9", 0, 0, 8'h90);
        put_bytes(5, 0, 1'b1, 1'b1, 1'b1, 8'h5A);
        drain("R9", 5, 1, 8'h5A);
        check("R9", "overflow still set", int'(overflow), 1);

        // R1 reset clears sticky state
        do_reset();
        check("R1", "overflow after reset", int'(overflow), 0);
        check("R1", "dma_req after reset", int'(dma_req), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule